// File: doc/BRIEF.md
# Interrupt Pending and Mask Unit

This block keeps an eight-line interrupt-pending vector and decides when the core should take an interrupt exception. Software-side agents post or clear individual lines by number, or wipe the whole vector at once. A built-in count/compare timer can also raise a line: when the two values match and the count is non-zero, the line chosen by a three-bit selector is set.

An interrupt request is raised only when the global enable is on and neither the error level nor the exception level is active. Under those conditions, any line that is both pending and unmasked raises the request. The request is registered, so it follows the pending vector and the control inputs with one cycle of delay. A separate flag reports whether any line is pending at all, without regard to mask or enable. Line numbers are four bits wide, so a request can name a line that does not exist. Such a request is dropped and reported on an error output.

Top module: `irq_pend_unit`

## Requirements
- R1: While `rst` is high at a rising edge, the pending vector is cleared. In the cycle after reset, `pend_vec`, `irq_req`, `any_pend` and `req_err` all read 0.
- R2: A post with `post_vld`=1 and `post_line`=n, for n in 0..7, sets bit n of `pend_vec` at the next edge. All other bits keep their values.
- R3: A clear with `clr_vld`=1 and `clr_line`=n, for n in 0..7, clears bit n of `pend_vec` at the next edge. All other bits keep their values.
- R4: `clr_all`=1 sets all eight bits of `pend_vec` to 0 at the next edge, unless a set hits a bit in the same cycle.
- R5: A post or clear that names a line in 8..15 leaves `pend_vec` unchanged. `req_err` is 1 in the cycle after such a request and 0 otherwise.
- R6: `irq_req` is 0 in any cycle after an edge at which `glb_en` was 0, `err_lvl` was 1 or `exc_lvl` was 1.
- R7: When the enable conditions held at an edge, `irq_req` after that edge equals the OR of (`line_mask` AND `pend_vec`) as sampled at that edge. This is one register stage behind the pending vector.
- R8: When `tmr_compare` equals `tmr_count` and `tmr_count` is non-zero, bit `tmr_sel` of `pend_vec` is set at the next edge.
- R9: When `tmr_count` is zero, equal compare and count values set no bit.
- R10: `any_pend` is 1 exactly when `pend_vec` is non-zero, whatever `line_mask`, `glb_en`, `err_lvl` and `exc_lvl` are.
- R11: When a set (post or timer match) and a clear (single or all) hit the same bit in the same cycle, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| post_vld | input | 1 | Post request strobe |
| post_line | input | 4 | Line number to post |
| clr_vld | input | 1 | Clear request strobe |
| clr_line | input | 4 | Line number to clear |
| clr_all | input | 1 | Clear every pending line |
| glb_en | input | 1 | Global interrupt enable |
| err_lvl | input | 1 | Error level active, blocks interrupts |
| exc_lvl | input | 1 | Exception level active, blocks interrupts |
| line_mask | input | 8 | Per-line interrupt mask, 1 = allowed |
| tmr_count | input | 32 | Free-running count value |
| tmr_compare | input | 32 | Timer compare value |
| tmr_sel | input | 3 | Line raised by a timer match |
| pend_vec | output | 8 | Pending vector |
| irq_req | output | 1 | Registered interrupt request |
| any_pend | output | 1 | Any line pending |
| req_err | output | 1 | Out-of-range request seen last cycle |

## Verification
The assertions assume that every input is a known value from the first edge after reset. They also assume that post and clear strobes are sampled only at rising edges, and that a set/clear conflict on one bit is resolved toward the set. The stimulus changes inputs just after an edge and holds them for whole cycles. It keeps the timer count at zero, or at a value different from compare, except in the cycles where a timer match is intended. This prevents unplanned timer sets from overlapping the post, clear and mask scenarios.

// File: rtl/irq_pkg.sv
package irq_pkg;

    localparam int NUM_LINES  = 8;
    localparam int LINE_IDX_W = $clog2(NUM_LINES);
    localparam int REQ_IDX_W  = LINE_IDX_W + 1;
    localparam int CNT_W      = 32;

    typedef logic [NUM_LINES-1:0]  line_vec_t;
    typedef logic [REQ_IDX_W-1:0]  req_idx_t;
    typedef logic [LINE_IDX_W-1:0] line_idx_t;
    typedef logic [CNT_W-1:0]      cnt_t;

    // Gating inputs that decide whether a pending line may interrupt
    typedef struct packed {
        logic      gie;
        logic      err_lvl;
        logic      exc_lvl;
        line_vec_t mask;
    } irq_ctl_t;

    // Per-cycle update applied to the pending vector
    typedef struct packed {
        line_vec_t set_m;
        line_vec_t clr_m;
        logic      clr_all;
    } pend_upd_t;

    function automatic logic gate_open(input irq_ctl_t c);
        return c.gie && !c.err_lvl && !c.exc_lvl;
    endfunction

    function automatic logic idx_in_range(input req_idx_t idx);
        return idx < req_idx_t'(NUM_LINES);
    endfunction

endpackage

// File: rtl/irq_line_decode.sv
module irq_line_decode
    import irq_pkg::*;
(
    input  logic      vld,
    input  req_idx_t  idx,
    output line_vec_t hit,
    output logic      bad
);
    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        assign hit[i] = vld && (idx == req_idx_t'(i));
    end

    assign bad = vld && !idx_in_range(idx);
endmodule

// File: rtl/irq_tmr_match.sv
module irq_tmr_match
    import irq_pkg::*;
(
    input  cnt_t      count,
    input  cnt_t      compare,
    input  line_idx_t sel,
    output logic      match,
    output line_vec_t set_m
);
    assign match = (count == compare) && (count != '0);

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_sel
        assign set_m[i] = match && (sel == line_idx_t'(i));
    end
endmodule

// File: rtl/irq_pend_reg.sv
module irq_pend_reg
    import irq_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  pend_upd_t upd,
    output line_vec_t pend_q
);
    line_vec_t keep_m;
    line_vec_t pend_d;

    always_comb begin
        keep_m = upd.clr_all ? '0 : ~upd.clr_m;
        // sets are applied last so they win over any clear
        pend_d = (pend_q & keep_m) | upd.set_m;
    end

    always_ff @(posedge clk) begin
        if (rst) pend_q <= '0;
        else     pend_q <= pend_d;
    end

    // R3
    clear_only_target_chk: assert property (@(posedge clk) disable iff (rst)
        (upd.clr_m != '0 && upd.set_m == '0 && !upd.clr_all)
        |=> pend_q == ($past(pend_q) & ~$past(upd.clr_m)));

    // R4
    clear_all_chk: assert property (@(posedge clk) disable iff (rst)
        (upd.clr_all && upd.set_m == '0) |=> pend_q == '0);

    // R11
    set_beats_clear_chk: assert property (@(posedge clk) disable iff (rst)
        ((upd.set_m & (upd.clr_m | {NUM_LINES{upd.clr_all}})) != '0)
        |=> (pend_q & $past(upd.set_m)) == $past(upd.set_m));
endmodule

// File: rtl/irq_gate.sv
module irq_gate
    import irq_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  irq_ctl_t  ctl,
    input  line_vec_t pend,
    output logic      irq_q
);
    always_ff @(posedge clk) begin
        if (rst) irq_q <= 1'b0;
        else     irq_q <= gate_open(ctl) && ((ctl.mask & pend) != '0);
    end

    // R6
    gate_closed_chk: assert property (@(posedge clk) disable iff (rst)
        (!ctl.gie || ctl.err_lvl || ctl.exc_lvl) |=> !irq_q);

    // R7
    masked_pending_chk: assert property (@(posedge clk) disable iff (rst)
        (ctl.gie && !ctl.err_lvl && !ctl.exc_lvl && (ctl.mask & pend) != '0)
        |=> irq_q);
endmodule

// File: rtl/irq_pend_unit.sv
module irq_pend_unit
    import irq_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        post_vld,
    input  logic [3:0]  post_line,
    input  logic        clr_vld,
    input  logic [3:0]  clr_line,
    input  logic        clr_all,
    input  logic        glb_en,
    input  logic        err_lvl,
    input  logic        exc_lvl,
    input  logic [7:0]  line_mask,
    input  logic [31:0] tmr_count,
    input  logic [31:0] tmr_compare,
    input  logic [2:0]  tmr_sel,
    output logic [7:0]  pend_vec,
    output logic        irq_req,
    output logic        any_pend,
    output logic        req_err
);
    line_vec_t post_hit, clr_hit, tmr_set;
    logic      post_bad, clr_bad, tmr_hit;
    pend_upd_t upd;
    irq_ctl_t  ctl;
    line_vec_t pend_q;
    logic      err_q;

    irq_line_decode u_post_dec (
        .vld (post_vld), .idx (post_line), .hit (post_hit), .bad (post_bad)
    );

    irq_line_decode u_clr_dec (
        .vld (clr_vld), .idx (clr_line), .hit (clr_hit), .bad (clr_bad)
    );

    irq_tmr_match u_tmr (
        .count (tmr_count), .compare (tmr_compare), .sel (tmr_sel),
        .match (tmr_hit), .set_m (tmr_set)
    );

    always_comb begin
        upd.set_m   = post_hit | tmr_set;
        upd.clr_m   = clr_hit;
        upd.clr_all = clr_all;
        ctl.gie     = glb_en;
        ctl.err_lvl = err_lvl;
        ctl.exc_lvl = exc_lvl;
        ctl.mask    = line_mask;
    end

    irq_pend_reg u_pend (
        .clk (clk), .rst (rst), .upd (upd), .pend_q (pend_q)
    );

    irq_gate u_gate (
        .clk (clk), .rst (rst), .ctl (ctl), .pend (pend_q), .irq_q (irq_req)
    );

    always_ff @(posedge clk) begin
        if (rst) err_q <= 1'b0;
        else     err_q <= post_bad || clr_bad;
    end

    assign pend_vec = pend_q;
    assign any_pend = pend_q != '0;
    assign req_err  = err_q;

    // R2
    post_sets_line_chk: assert property (@(posedge clk) disable iff (rst)
        (post_vld && post_line < 4'd8) |=> pend_vec[$past(post_line[2:0])]);

    // R5
    bad_line_flag_chk: assert property (@(posedge clk) disable iff (rst)
        ((post_vld && post_line >= 4'd8) || (clr_vld && clr_line >= 4'd8))
        |=> req_err);

    // R5
    bad_line_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (post_vld && post_line >= 4'd8 && !clr_vld && !clr_all && !tmr_hit)
        |=> pend_vec == $past(pend_vec));

    // R8
    timer_sets_line_chk: assert property (@(posedge clk) disable iff (rst)
        (tmr_count == tmr_compare && tmr_count != '0)
        |=> pend_vec[$past(tmr_sel)]);
endmodule

// File: tb/irq_pend_unit_test.sv
module irq_pend_unit_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        post_vld = 1'b0, clr_vld = 1'b0, clr_all = 1'b0;
    logic [3:0]  post_line = '0, clr_line = '0;
    logic        glb_en = 1'b0, err_lvl = 1'b0, exc_lvl = 1'b0;
    logic [7:0]  line_mask = '0;
    logic [31:0] tmr_count = '0, tmr_compare = '0;
    logic [2:0]  tmr_sel = '0;
    logic [7:0]  pend_vec;
    logic        irq_req, any_pend, req_err;

    int n_vec = 0;
    int n_bad = 0;

    irq_pend_unit uut (.*);

    always #5 clk = ~clk;

    initial begin
        #1ms;
        n_bad++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle();
        post_vld = 1'b0; clr_vld = 1'b0; clr_all = 1'b0;
    endtask

    task automatic t_reset();
        rst = 1'b1; tick(); tick(); rst = 1'b0;
        chk("R1 pend", {24'b0, pend_vec}, 32'h0);
        chk("R1 irq", {31'b0, irq_req}, 32'h0);
        chk("R1 err", {31'b0, req_err}, 32'h0);
        chk("R10 any after reset", {31'b0, any_pend}, 32'h0);
    endtask

    task automatic t_post();
        post_vld = 1'b1; post_line = 4'd3; tick(); idle();
        chk("R2 post line 3", {24'b0, pend_vec}, 32'h08);
        post_vld = 1'b1; post_line = 4'd6; tick(); idle();
        chk("R2 post line 6", {24'b0, pend_vec}, 32'h48);
        chk("R10 any set", {31'b0, any_pend}, 32'h1);
    endtask

    task automatic t_clear();
        clr_vld = 1'b1; clr_line = 4'd3; tick(); idle();
        chk("R3 clear line 3", {24'b0, pend_vec}, 32'h40);
    endtask

    task automatic t_clear_all();
        post_vld = 1'b1; post_line = 4'd1; tick(); idle();
        chk("R2 post line 1", {24'b0, pend_vec}, 32'h42);
        clr_all = 1'b1; tick(); idle();
        chk("R4 clear all", {24'b0, pend_vec}, 32'h0);
    endtask

    task automatic t_bad_line();
        post_vld = 1'b1; post_line = 4'd9; tick(); idle();
        chk("R5 bad post ignored", {24'b0, pend_vec}, 32'h0);
        chk("R5 bad post flagged", {31'b0, req_err}, 32'h1);
        tick();
        chk("R5 flag drops", {31'b0, req_err}, 32'h0);
        post_vld = 1'b1; post_line = 4'd1; tick();
        post_line = 4'd6; tick(); idle();
        clr_vld = 1'b1; clr_line = 4'd12; tick(); idle();
        chk("R5 bad clear ignored", {24'b0, pend_vec}, 32'h42);
        chk("R5 bad clear flagged", {31'b0, req_err}, 32'h1);
    endtask

    task automatic t_gate();
        // pending is 0x42 here
        line_mask = 8'h02; glb_en = 1'b1;
        chk("R7 registered, not yet", {31'b0, irq_req}, 32'h0);
        tick();
        chk("R7 raise", {31'b0, irq_req}, 32'h1);
        err_lvl = 1'b1; tick();
        chk("R6 error level blocks", {31'b0, irq_req}, 32'h0);
        err_lvl = 1'b0; exc_lvl = 1'b1; tick();
        chk("R6 exception level blocks", {31'b0, irq_req}, 32'h0);
        exc_lvl = 1'b0; glb_en = 1'b0; tick();
        chk("R6 enable off blocks", {31'b0, irq_req}, 32'h0);
        glb_en = 1'b1; line_mask = 8'h01; tick();
        chk("R7 no overlap", {31'b0, irq_req}, 32'h0);
        chk("R10 any ignores mask", {31'b0, any_pend}, 32'h1);
        line_mask = 8'h40; tick();
        chk("R7 line 6 unmasked", {31'b0, irq_req}, 32'h1);
        clr_all = 1'b1; tick(); idle();
        chk("R7 still one stage behind", {31'b0, irq_req}, 32'h1);
        tick();
        chk("R7 drops after clear", {31'b0, irq_req}, 32'h0);
        glb_en = 1'b0; line_mask = 8'h00;
    endtask

    task automatic t_timer();
        tmr_count = 32'd0; tmr_compare = 32'd0; tmr_sel = 3'd5; tick();
        chk("R9 zero count no match", {24'b0, pend_vec}, 32'h0);
        tmr_count = 32'd7; tmr_compare = 32'd8; tick();
        chk("R8 no match when unequal", {24'b0, pend_vec}, 32'h0);
        tmr_count = 32'd8; tick();
        chk("R8 match sets line 5", {24'b0, pend_vec}, 32'h20);
        // match still live while line 5 is cleared
        clr_vld = 1'b1; clr_line = 4'd5; tick(); idle();
        chk("R11 timer beats clear", {24'b0, pend_vec}, 32'h20);
        tmr_count = 32'd9; clr_vld = 1'b1; clr_line = 4'd5; tick(); idle();
        chk("R3 clear after match ends", {24'b0, pend_vec}, 32'h0);
        tmr_count = 32'd0; tmr_compare = 32'd0;
    endtask

    task automatic t_set_wins();
        post_vld = 1'b1; post_line = 4'd2;
        clr_vld = 1'b1; clr_line = 4'd2; tick(); idle();
        chk("R11 post beats clear", {24'b0, pend_vec}, 32'h04);
        post_vld = 1'b1; post_line = 4'd7; clr_all = 1'b1; tick(); idle();
        chk("R11 post beats clear all", {24'b0, pend_vec}, 32'h80);
    endtask

    initial begin
        t_reset();
        t_post();
        t_clear();
        t_clear_all();
        t_bad_line();
        t_gate();
        t_timer();
        t_set_wins();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule